// File: doc/BRIEF.md
# Interlaced Field Cadence Sequencer

This block decides which field of a decoded frame goes to an interlaced display at each field time. On every field tick it shows either the top (odd-line) field or the bottom (even-line) field. Normal frames occupy two field times. A frame flagged for repetition occupies three, and its opening field is shown again in the third slot, which produces 3:2 pulldown. A two-bit freeze control can stop the flow of frames in three different ways.

The repeat and field-order controls come from one of two places, chosen by a register bit: per-frame flags carried with the decoded stream, or bits written by the host. Either way they are captured only when a new frame begins. The block reports the parity of the field on display, whether it is the opening or closing field of its frame, and a one-cycle request asking the frame buffer manager for the next frame. The host sets the controls and reads the status through a small synchronous register port.

Top module: `field_cadence_seq`

## Requirements
- R1: After reset the control register reads freeze code 00, stream source bit 1, host repeat bit 0 and host top-first bit 1; the status shows a bottom field with last-field 1, first-field 0, and no frame request.
- R2: Address 0 is the control register with freeze code in bits [1:0], source select in bit 2, host repeat in bit 3 and host top-first in bit 4. Address 1 is read-only status with bit 0 top-field, bit 1 first-field, bit 2 last-field. A write to address 1 changes nothing.
- R3: With freeze code 00, a tick during a frame's last field starts a new frame: the opening field is top when top-first is 1 and bottom otherwise, first-field is 1, and the frame request is high for exactly one cycle. In a two-field frame the next tick shows the opposite parity with last-field 1.
- R4: When repeat is 1 a frame lasts three ticks: opening parity, opposite parity, then the opening parity again. During the middle field first-field and last-field are both 0; the third field has last-field 1.
- R5: With source select 1, repeat and top-first come from the stream flag inputs; with 0 they come from host bits 3 and 4.
- R6: Repeat and top-first are captured only when a new frame starts; changing them mid-frame alters only the next frame.
- R7: Freeze code 01 alternates parity on every tick within the current frame, reporting first-field on the opening parity and last-field on the other, and raises no frame request.
- R8: Freeze code 10 lets the current frame advance to its last field, then shows that field on every tick with no frame request.
- R9: Freeze code 11 lets the sequence run until an opening field is on display (this may start one new frame), then shows that field on every tick with no further frame request.
- R10: Field outputs change only on the clock edge where a tick is sampled; between ticks they stay fixed and the frame request stays low.
- R11: Returning the freeze code to 00 resumes normal sequencing from the held field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fld_tick | input | 1 | One-cycle pulse marking a field time |
| bs_rpt_first | input | 1 | Stream flag: repeat the opening field of the next frame |
| bs_top_first | input | 1 | Stream flag: next frame opens with the top field |
| host_we | input | 1 | Host write enable |
| host_addr | input | 2 | Host register address (write and read) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_addr |
| fld_is_top | output | 1 | Field on display is the top field |
| fld_first | output | 1 | Field on display opens its frame |
| fld_last | output | 1 | Field on display closes its frame |
| frame_adv | output | 1 | One-cycle request for the next frame |

## Verification
The cadence is driven with two-field frames of both orders, three-field frames that open with either parity, and a mid-frame change of the controls; the first two separate parity mistakes from length mistakes, and the last shows whether controls are captured only at the frame boundary. Stream flags are held opposite to the host bits so the source select visibly changes the result. Each freeze code is entered at a point that distinguishes it from the others: freeze-last from a middle field, freeze-first from a last field where it must still start one frame, and freeze-frame from an opening field where it must alternate without any request.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [1:0] {
        FRZ_NONE  = 2'b00,
        FRZ_FRAME = 2'b01,
        FRZ_LAST  = 2'b10,
        FRZ_FIRST = 2'b11
    } freeze_e;

    typedef struct packed {
        freeze_e frz;
        logic    pd_from_bs;
        logic    host_rpt;
        logic    host_top;
    } ctrl_t;

    typedef struct packed {
        logic [1:0] phase;
        logic       three;
        logic       top_first;
        logic       is_top;
    } seq_t;

    localparam int CTRL_IDX = 0;
    localparam int STAT_IDX = 1;

    localparam int FRZ_LSB = 0;
    localparam int SRC_BIT = 2;
    localparam int RPT_BIT = 3;
    localparam int TOP_BIT = 4;
    localparam int CTRL_BITS = 5;

    localparam int ST_TOP   = 0;
    localparam int ST_FIRST = 1;
    localparam int ST_LAST  = 2;

    localparam ctrl_t CTRL_RESET = '{frz: FRZ_NONE, pd_from_bs: 1'b1,
                                     host_rpt: 1'b0, host_top: 1'b1};

    localparam seq_t SEQ_RESET = '{phase: 2'd1, three: 1'b0,
                                   top_first: 1'b1, is_top: 1'b0};

    function automatic logic phase_is_last(seq_t s);
        return s.three ? (s.phase == 2'd2) : (s.phase == 2'd1);
    endfunction

    function automatic logic parity_at(logic [1:0] ph, logic tf);
        return (ph == 2'd1) ? ~tf : tf;
    endfunction

endpackage

// File: rtl/fcs_regs.sv
module fcs_regs
    import fcs_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          st_top,
    input  logic          st_first,
    input  logic          st_last,
    output ctrl_t         ctrl,
    output logic [DW-1:0] rdata
);
    localparam logic [AW-1:0] A_CTRL = AW'(CTRL_IDX);
    localparam logic [AW-1:0] A_STAT = AW'(STAT_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= CTRL_RESET;
        end else if (we && addr == A_CTRL) begin
            ctrl.frz        <= freeze_e'(wdata[FRZ_LSB +: 2]);
            ctrl.pd_from_bs <= wdata[SRC_BIT];
            ctrl.host_rpt   <= wdata[RPT_BIT];
            ctrl.host_top   <= wdata[TOP_BIT];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL) begin
            rdata[FRZ_LSB +: 2] = ctrl.frz;
            rdata[SRC_BIT]      = ctrl.pd_from_bs;
            rdata[RPT_BIT]      = ctrl.host_rpt;
            rdata[TOP_BIT]      = ctrl.host_top;
        end else if (addr == A_STAT) begin
            rdata[ST_TOP]   = st_top;
            rdata[ST_FIRST] = st_first;
            rdata[ST_LAST]  = st_last;
        end
    end

    // R1: control defaults after reset
    a_r1_ctrl_reset: assert property (@(posedge clk)
        rst |=> (ctrl == CTRL_RESET));

    // R2: writes aimed at the status address leave control untouched
    a_r2_stat_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_STAT) |=> $stable(ctrl));

endmodule

// File: rtl/fcs_pd_src.sv
module fcs_pd_src
    import fcs_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  bs_rpt,
    input  logic  bs_top,
    output logic  rpt,
    output logic  tff
);
    always_comb begin
        if (ctrl.pd_from_bs) begin
            rpt = bs_rpt;
            tff = bs_top;
        end else begin
            rpt = ctrl.host_rpt;
            tff = ctrl.host_top;
        end
    end
endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
    import fcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  ctrl_t ctrl,
    input  logic  rpt,
    input  logic  tff,
    output logic  is_top,
    output logic  first,
    output logic  last,
    output logic  adv
);
    seq_t cur, nxt;
    logic adv_nxt;
    logic at_last, at_first, step;

    assign at_last  = phase_is_last(cur);
    assign at_first = (cur.phase == 2'd0);

    always_comb begin
        nxt     = cur;
        adv_nxt = 1'b0;
        step    = 1'b0;
        if (tick) begin
            unique case (ctrl.frz)
                FRZ_NONE:  step = 1'b1;
                FRZ_FRAME: begin
                    nxt.is_top = ~cur.is_top;
                    nxt.phase  = (~cur.is_top == cur.top_first) ? 2'd0
                               : (cur.three ? 2'd2 : 2'd1);
                end
                FRZ_LAST:  step = !at_last;
                FRZ_FIRST: step = !at_first;
            endcase
            if (step) begin
                if (at_last) begin
                    nxt.phase     = 2'd0;
                    nxt.three     = rpt;
                    nxt.top_first = tff;
                    nxt.is_top    = tff;
                    adv_nxt       = 1'b1;
                end else begin
                    nxt.phase  = cur.phase + 2'd1;
                    nxt.is_top = parity_at(cur.phase + 2'd1, cur.top_first);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= SEQ_RESET;
            adv <= 1'b0;
        end else begin
            cur <= nxt;
            adv <= adv_nxt;
        end
    end

    assign is_top = cur.is_top;
    assign first  = at_first;
    assign last   = at_last;

    // R3: a request always coincides with an opening field of the new order
    a_r3_adv_on_opening: assert property (@(posedge clk) disable iff (rst)
        adv |-> (first && is_top == cur.top_first));

    // R3: normal tick on a closing field starts a frame
    a_r3_new_frame: assert property (@(posedge clk) disable iff (rst)
        (tick && ctrl.frz == FRZ_NONE && last) |=> (first && adv));

    // R4: opening and closing never reported together
    a_r4_flags_excl: assert property (@(posedge clk) disable iff (rst)
        !(first && last));

    // R7: freeze-frame and freeze-last never request a frame
    a_r7_no_adv_frozen: assert property (@(posedge clk) disable iff (rst)
        (tick && (ctrl.frz == FRZ_FRAME || ctrl.frz == FRZ_LAST)) |=> !adv);

    // R8: freeze-last holds a closing field
    a_r8_last_hold: assert property (@(posedge clk) disable iff (rst)
        (tick && ctrl.frz == FRZ_LAST && last) |=> (last && $stable(is_top)));

    // R9: freeze-first holds an opening field
    a_r9_first_hold: assert property (@(posedge clk) disable iff (rst)
        (tick && ctrl.frz == FRZ_FIRST && first) |=> (first && !adv && $stable(is_top)));

    // R10: nothing moves without a tick
    a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(cur) && !adv));

endmodule

// File: rtl/field_cadence_seq.sv
module field_cadence_seq
    import fcs_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fld_tick,
    input  logic          bs_rpt_first,
    input  logic          bs_top_first,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          fld_is_top,
    output logic          fld_first,
    output logic          fld_last,
    output logic          frame_adv
);
    ctrl_t ctrl;
    logic  rpt_sel, tff_sel;

    fcs_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (host_we),
        .addr     (host_addr),
        .wdata    (host_wdata),
        .st_top   (fld_is_top),
        .st_first (fld_first),
        .st_last  (fld_last),
        .ctrl     (ctrl),
        .rdata    (host_rdata)
    );

    fcs_pd_src u_src (
        .ctrl   (ctrl),
        .bs_rpt (bs_rpt_first),
        .bs_top (bs_top_first),
        .rpt    (rpt_sel),
        .tff    (tff_sel)
    );

    fcs_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .tick   (fld_tick),
        .ctrl   (ctrl),
        .rpt    (rpt_sel),
        .tff    (tff_sel),
        .is_top (fld_is_top),
        .first  (fld_first),
        .last   (fld_last),
        .adv    (frame_adv)
    );
endmodule

// File: tb/field_cadence_seq_tb.sv
module field_cadence_seq_tb;
    localparam time CLK_P = 8ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fld_tick = 1'b0;
    logic       bs_rpt_first = 1'b0;
    logic       bs_top_first = 1'b0;
    logic       host_we = 1'b0;
    logic [1:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       fld_is_top, fld_first, fld_last, frame_adv;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    field_cadence_seq u_dut (
        .clk(clk), .rst(rst), .fld_tick(fld_tick),
        .bs_rpt_first(bs_rpt_first), .bs_top_first(bs_top_first),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .fld_is_top(fld_is_top),
        .fld_first(fld_first), .fld_last(fld_last), .frame_adv(frame_adv)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    // expected {top, first, last, adv}
    task automatic chk_fld(input string req, input logic [3:0] exp);
        chk(req, "field {top,first,last,adv}",
            {28'd0, fld_is_top, fld_first, fld_last, frame_adv}, {28'd0, exp});
    endtask

    task automatic tick();
        @(negedge clk); fld_tick = 1'b1;
        @(negedge clk); fld_tick = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk); host_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); host_addr = a; #1; d = host_rdata;
    endtask

    task automatic sync_last();
        for (int i = 0; i < 4 && !fld_last; i++) tick();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        @(negedge clk);
        chk_fld("R1", 4'b0010);
        rd(2'd0, d); chk("R1", "control default", {24'd0, d}, 32'h14);
        rd(2'd1, d); chk("R1", "status default", {24'd0, d}, 32'h04);
    endtask

    task automatic t_normal();
        wr(2'd0, 8'h10); sync_last();
        tick(); chk_fld("R3", 4'b1101);
        @(negedge clk); chk("R3", "request one cycle", {31'd0, frame_adv}, 0);
        tick(); chk_fld("R3", 4'b0010);
        wr(2'd0, 8'h00);
        tick(); chk_fld("R3", 4'b0101);
        tick(); chk_fld("R3", 4'b1010);
    endtask

    task automatic t_pulldown();
        logic [7:0] d;
        wr(2'd0, 8'h18); sync_last();
        tick(); chk_fld("R4", 4'b1101);
        tick(); chk_fld("R4", 4'b0000);
        rd(2'd1, d); chk("R2", "status middle", {24'd0, d}, 32'h00);
        tick(); chk_fld("R4", 4'b1010);
        rd(2'd1, d); chk("R2", "status last top", {24'd0, d}, 32'h05);
        tick(); chk_fld("R4", 4'b1101);
    endtask

    task automatic t_source();
        bs_rpt_first = 1'b1; bs_top_first = 1'b0;
        wr(2'd0, 8'h14); sync_last();
        tick(); chk_fld("R5", 4'b0101);
        tick(); chk_fld("R5", 4'b1000);
        tick(); chk_fld("R5", 4'b0010);
        wr(2'd0, 8'h10);
        tick(); chk_fld("R5", 4'b1101);
        tick(); chk_fld("R5", 4'b0010);
    endtask

    task automatic t_boundary();
        wr(2'd0, 8'h10); sync_last();
        tick(); chk_fld("R6", 4'b1101);
        wr(2'd0, 8'h08);
        tick(); chk_fld("R6", 4'b0010);
        tick(); chk_fld("R6", 4'b0101);
        tick(); chk_fld("R6", 4'b1000);
        tick(); chk_fld("R6", 4'b0010);
    endtask

    task automatic t_freeze_frame();
        wr(2'd0, 8'h10); sync_last();
        tick(); chk_fld("R7", 4'b1101);
        wr(2'd0, 8'h11);
        tick(); chk_fld("R7", 4'b0010);
        tick(); chk_fld("R7", 4'b1100);
        tick(); chk_fld("R7", 4'b0010);
    endtask

    task automatic t_freeze_last();
        wr(2'd0, 8'h18); sync_last();
        tick(); chk_fld("R8", 4'b1101);
        wr(2'd0, 8'h1A);
        tick(); chk_fld("R8", 4'b0000);
        tick(); chk_fld("R8", 4'b1010);
        tick(); chk_fld("R8", 4'b1010);
        tick(); chk_fld("R8", 4'b1010);
        wr(2'd0, 8'h18);
        tick(); chk_fld("R11", 4'b1101);
    endtask

    task automatic t_freeze_first();
        wr(2'd0, 8'h10); sync_last();
        wr(2'd0, 8'h13);
        tick(); chk_fld("R9", 4'b1101);
        tick(); chk_fld("R9", 4'b1100);
        tick(); chk_fld("R9", 4'b1100);
        wr(2'd0, 8'h10);
        tick(); chk_fld("R11", 4'b0010);
    endtask

    task automatic t_quiet_and_ro();
        logic [7:0] d;
        wr(2'd0, 8'h10); sync_last();
        tick(); chk_fld("R10", 4'b1101);
        repeat (5) @(negedge clk);
        chk_fld("R10", 4'b1100);
        wr(2'd1, 8'hFF);
        rd(2'd1, d); chk("R2", "status after write", {24'd0, d}, 32'h03);
        rd(2'd0, d); chk("R2", "control after status write", {24'd0, d}, 32'h10);
        wr(2'd0, 8'h1B);
        rd(2'd0, d); chk("R2", "control readback", {24'd0, d}, 32'h1B);
        wr(2'd0, 8'h10);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_normal();
        t_pulldown();
        t_source();
        t_boundary();
        t_freeze_frame();
        t_freeze_last();
        t_freeze_first();
        t_quiet_and_ro();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule